// File: doc/BRIEF.md
# Single-Accumulator Load/Add/Store Processor

This block is a small sequencing core built around one 16-bit accumulator. It steps through a program held in an external word-addressed memory of 4096 words. Each instruction word carries a 4-bit operation code in its top nibble and a 12-bit direct operand address below it. The core knows three operations: copy a memory word into the accumulator, add a memory word to it, and write it back to memory. Any other operation code stops the core until the next reset.

Each instruction takes two clock cycles. In the fetch cycle the core presents the program counter on the address port and latches the returned word. In the execute cycle it presents the operand address, then either takes in the read data or drives a write. The memory is outside the block. Its read port is combinational, so the word for the address on `mem_addr` arrives on `mem_rdata` in the same cycle, and it writes on the rising clock edge while `mem_wr_en` is high. After reset the core begins at a non-zero program address. In the intended use, four instructions starting at 0x101 add the three words at 0x201..0x203 and place the total at 0x204.

Top module: `accm_core`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `mem_addr` is 0x101, `mem_wr_en` is 0 and `halted` is 0. The accumulator starts at 0, so an add followed by a store with no earlier load stores the added word unchanged.
- R2: An instruction word is split into an operation code in bits [15:12] and an operand address in bits [11:0]. The whole 12-bit range, 0x000 to 0xFFF, can be reached as an operand address.
- R3: Each instruction takes one fetch cycle and then one execute cycle. In the k-th fetch cycle after reset (k counted from 0), `mem_addr` is 0x101+k and `mem_wr_en` is 0.
- R4: Operation code 2 replaces the accumulator with memory[address]. The earlier accumulator value is discarded.
- R5: Operation code 1 adds memory[address] to the accumulator, and the sum wraps modulo 2^16. No other operation changes the accumulator.
- R6: Operation code 3 writes the accumulator to memory[address]. For exactly one cycle, the execute cycle, the core drives `mem_wr_en`=1, `mem_addr`=address and `mem_wdata`=accumulator. No other cycle asserts `mem_wr_en`.
- R7: Any operation code other than 1, 2 or 3 sets `halted` at the end of its execute cycle. That instruction writes nothing. From then until reset, `halted` stays 1, `mem_wr_en` stays 0 and `mem_addr` stays fixed.
- R8: Take the program 0x2201, 0x1202, 0x1203, 0x3204 at 0x101 with an operation code 0 word after it, and data 2, 3, 4 at 0x201..0x203. This program leaves 9 at 0x204, and `halted` rises after exactly 10 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Word read from memory at `mem_addr`, same cycle |
| mem_addr | output | 12 | Word address: program counter in fetch, operand address in execute |
| mem_wr_en | output | 1 | Memory write strobe, high only in the execute cycle of a store |
| mem_wdata | output | 16 | Accumulator value, written when `mem_wr_en` is high |
| halted | output | 1 | High once an unknown operation code has run |

## Verification
A wrong program counter or a wrong phase shows at `mem_addr` by the next fetch cycle, two edges at most after the fault. A stepping error also shifts how many edges pass before `halted` rises. A wrong accumulator stays hidden until the next store, which then writes a wrong value or writes to a wrong address. For that reason the bench runs many short programs whose stores come right after each load or add, and compares every stored word with sums computed in the bench. Faults in halting show as a write, or as a moving address, during the idle cycles after `halted` rises.

// File: rtl/accm_pkg.sv
package accm_pkg;
    parameter int DATA_W = 16;
    parameter int OP_W   = 4;
    localparam int ADDR_W = DATA_W - OP_W;

    localparam logic [OP_W-1:0] OPC_ADD   = OP_W'(1);
    localparam logic [OP_W-1:0] OPC_LOAD  = OP_W'(2);
    localparam logic [OP_W-1:0] OPC_STORE = OP_W'(3);

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_HALT  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        ACT_LOAD  = 2'd0,
        ACT_ADD   = 2'd1,
        ACT_STORE = 2'd2,
        ACT_STOP  = 2'd3
    } act_e;

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [ADDR_W-1:0] addr;
    } instr_t;

    function automatic act_e decode_op(input logic [OP_W-1:0] op);
        act_e a;
        case (op)
            OPC_LOAD:  a = ACT_LOAD;
            OPC_ADD:   a = ACT_ADD;
            OPC_STORE: a = ACT_STORE;
            default:   a = ACT_STOP;
        endcase
        return a;
    endfunction
endpackage

// File: rtl/accm_seq.sv
module accm_seq
    import accm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] fetch_word,
    output phase_e            phase,
    output logic [ADDR_W-1:0] pc,
    output instr_t            ir,
    output act_e              act,
    output logic              halted
);
    always_comb act = decode_op(ir.op);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_FETCH;
            pc     <= RESET_PC;
            ir     <= '0;
            halted <= 1'b0;
        end else begin
            case (phase)
                PH_FETCH: begin
                    ir    <= instr_t'(fetch_word);
                    pc    <= pc + ADDR_W'(1);
                    phase <= PH_EXEC;
                end
                PH_EXEC: begin
                    if (act == ACT_STOP) begin
                        phase  <= PH_HALT;
                        halted <= 1'b1;
                    end else begin
                        phase <= PH_FETCH;
                    end
                end
                default: phase <= PH_HALT;
            endcase
        end
    end

    assert_pc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |-> (pc == $past(pc) + ADDR_W'(1)));

    assert_halt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted);

    assert_halt_source_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(halted) |-> ($past(phase) == PH_EXEC && $past(act) == ACT_STOP));
endmodule

// File: rtl/accm_exec.sv
module accm_exec
    import accm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  act_e              act,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc
);
    logic [DATA_W-1:0] acc_next;

    always_comb begin
        acc_next = acc;
        if (exec_en) begin
            case (act)
                ACT_LOAD: acc_next = operand;
                ACT_ADD:  acc_next = acc + operand;
                default:  acc_next = acc;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc <= '0;
        else     acc <= acc_next;
    end

    assert_load_replace_R4: assert property (@(posedge clk) disable iff (rst)
        (exec_en && act == ACT_LOAD) |=> (acc == $past(operand)));

    assert_acc_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !(exec_en && (act == ACT_LOAD || act == ACT_ADD)) |=> $stable(acc));
endmodule

// File: rtl/accm_core.sv
module accm_core
    import accm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] RESET_PC = 12'h101
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr_en,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              halted
);
    phase_e            phase;
    logic [ADDR_W-1:0] pc;
    instr_t            ir;
    act_e              act;
    logic              in_exec;
    logic [DATA_W-1:0] acc;

    accm_seq #(.RESET_PC(RESET_PC)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .fetch_word(mem_rdata),
        .phase     (phase),
        .pc        (pc),
        .ir        (ir),
        .act       (act),
        .halted    (halted)
    );

    assign in_exec = (phase == PH_EXEC);

    accm_exec exec_i (
        .clk    (clk),
        .rst    (rst),
        .exec_en(in_exec),
        .act    (act),
        .operand(mem_rdata),
        .acc    (acc)
    );

    assign mem_addr  = in_exec ? ir.addr : pc;
    assign mem_wr_en = in_exec && (act == ACT_STORE);
    assign mem_wdata = acc;

    assert_write_in_exec_R6: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (phase == PH_EXEC));

    assert_quiet_halt_R7: assert property (@(posedge clk) disable iff (rst)
        halted |-> (!mem_wr_en && (phase == PH_HALT)));

    assert_addr_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        (halted && $past(halted)) |-> $stable(mem_addr));

    assert_reset_fetch_R1: assert property (@(posedge clk)
        $past(rst) |-> (mem_addr == RESET_PC && !mem_wr_en));
endmodule

// File: tb/accm_core_tb_top.sv
module accm_core_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [11:0] START = 12'h101;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata;
    logic [11:0] mem_addr;
    logic        mem_wr_en;
    logic [15:0] mem_wdata;
    logic        halted;

    logic [15:0] mem [0:4095];
    logic        clr = 1'b0;
    logic        pl_en = 1'b0;
    logic [11:0] pl_addr = '0;
    logic [15:0] pl_data = '0;
    int          wr_count = 0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    accm_core dut_i (
        .clk      (clk),
        .rst      (rst),
        .mem_rdata(mem_rdata),
        .mem_addr (mem_addr),
        .mem_wr_en(mem_wr_en),
        .mem_wdata(mem_wdata),
        .halted   (halted)
    );

    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= 16'h0;
            wr_count <= 0;
        end else if (pl_en) begin
            mem[pl_addr] <= pl_data;
        end else if (mem_wr_en) begin
            mem[mem_addr] <= mem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic start_prog();
        @(negedge clk);
        rst = 1'b1;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    // releases reset, runs to halt; returns edges and whether every fetch address was right (R3)
    task automatic run(output int edges, output bit fetch_ok);
        rst = 1'b0;
        edges = 0;
        fetch_ok = 1'b1;
        while (!halted && edges < 200) begin
            if (edges % 2 == 0)
                if (mem_addr != START + 12'(edges / 2) || mem_wr_en) fetch_ok = 1'b0;
            @(posedge clk);
            @(negedge clk);
            edges++;
        end
    endtask

    initial begin
        int e;
        bit fok;

        // R1: reset state
        start_prog();
        chk(mem_addr == START, "R1 reset addr", int'(mem_addr), int'(START));
        chk(!mem_wr_en && !halted, "R1 reset outputs", int'({mem_wr_en, halted}), 0);
        rst = 1'b0;
        chk(mem_addr == START && !mem_wr_en && !halted, "R1 first cycle", int'(mem_addr), int'(START));
        @(negedge clk);

        // R8 reference program
        start_prog();
        put(12'h101, 16'h2201); put(12'h102, 16'h1202);
        put(12'h103, 16'h1203); put(12'h104, 16'h3204);
        put(12'h201, 16'd2); put(12'h202, 16'd3); put(12'h203, 16'd4);
        run(e, fok);
        chk(mem[12'h204] == 16'd9, "R8 sum", int'(mem[12'h204]), 9);
        chk(e == 10, "R8 halt edges", e, 10);
        chk(fok, "R3 fetch sequence", 0, 1);
        chk(wr_count == 1, "R6 single write", wr_count, 1);
        chk(halted, "R7 halted", int'(halted), 1);

        // R5 sweep of sums with wrap
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                logic [15:0] a, b, c, s;
                a = 16'(i * 16'h2493 + (i == 7 ? 16'h8000 : 16'h0));
                b = 16'(j * 16'h5A5B);
                c = 16'((i ^ j) * 16'h3C3D + 16'hFFF0);
                s = 16'((32'(a) + 32'(b) + 32'(c)) % 32'h10000);
                start_prog();
                put(12'h101, 16'h2201); put(12'h102, 16'h1202);
                put(12'h103, 16'h1203); put(12'h104, 16'h3204);
                put(12'h201, a); put(12'h202, b); put(12'h203, c);
                run(e, fok);
                chk(mem[12'h204] == s, "R5 wrapped sum", int'(mem[12'h204]), int'(s));
                chk(fok && e == 10, "R3 step count", e, 10);
            end
        end

        // R4: second load discards earlier sum; stores after each step (R6)
        start_prog();
        put(12'h101, 16'h2201); put(12'h102, 16'h1202); put(12'h103, 16'h3205);
        put(12'h104, 16'h2203); put(12'h105, 16'h3204);
        put(12'h201, 16'h1111); put(12'h202, 16'h2222); put(12'h203, 16'h0ABC);
        run(e, fok);
        chk(mem[12'h205] == 16'h3333, "R5 add then store", int'(mem[12'h205]), 16'h3333);
        chk(mem[12'h204] == 16'h0ABC, "R4 load replaces", int'(mem[12'h204]), 16'h0ABC);
        chk(wr_count == 2, "R6 two writes", wr_count, 2);
        chk(e == 12, "R3 six instructions", e, 12);

        // R1: accumulator starts at zero
        start_prog();
        put(12'h101, 16'h1201); put(12'h102, 16'h3204);
        put(12'h201, 16'hBEEF);
        run(e, fok);
        chk(mem[12'h204] == 16'hBEEF, "R1 acc zero", int'(mem[12'h204]), 16'hBEEF);

        // R2: address field extremes
        start_prog();
        put(12'h101, 16'h2FFF); put(12'h102, 16'h3000);
        put(12'hFFF, 16'h5A5A);
        run(e, fok);
        chk(mem[12'h000] == 16'h5A5A, "R2 addr extremes", int'(mem[12'h000]), 16'h5A5A);
        chk(mem[12'hFFF] == 16'h5A5A, "R2 source intact", int'(mem[12'hFFF]), 16'h5A5A);

        // R7: every other op code halts with no write
        for (int op = 0; op < 16; op++) begin
            logic [11:0] held;
            if (op >= 1 && op <= 3) continue;
            start_prog();
            put(12'h101, {4'(op), 12'h204});
            put(12'h204, 16'h5555);
            run(e, fok);
            chk(e == 2 && halted, "R7 halt edges", e, 2);
            held = mem_addr;
            for (int k = 0; k < 4; k++) begin
                @(posedge clk); @(negedge clk);
                if (mem_wr_en || !halted || mem_addr != held) begin
                    chk(1'b0, "R7 idle after halt", int'(mem_addr), int'(held));
                    break;
                end
            end
            chk(wr_count == 0 && mem[12'h204] == 16'h5555, "R7 no write", wr_count, 0);
        end

        // R7: halt mid-program blocks a later store
        start_prog();
        put(12'h101, 16'h2201); put(12'h102, 16'hF000); put(12'h103, 16'h3204);
        put(12'h201, 16'h0077);
        run(e, fok);
        chk(e == 4 && mem[12'h204] == 16'h0 && wr_count == 0, "R7 mid halt",
            int'(mem[12'h204]), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule